// File: doc/BRIEF.md
# Network Adapter Bus-Interface Register File

This block holds the host-visible configuration registers of an Ethernet adapter that can sit in either an 8-bit or a 16-bit expansion slot. The host reaches it through a 16-byte I/O window. A write strobe with a byte of data changes a register. Reads are combinational from the stored state, selected by the window offset. The lower eight offsets are writable configuration storage. The upper eight form a read-only area: a six-byte station address, a card identity byte and a checksum byte.

From the stored contents the block continuously derives the configuration that the rest of the adapter needs: whether shared memory is enabled, the base address and size of the shared-memory window, the 16-bit transfer flags, and the interrupt line the card raises. A strap input tells the block whether the card is in a 16-bit slot. That strap fixes the bus-width bit and selects how the window base is formed.

Top module: `busIfRegFile`

## Requirements
- R1: After reset, offsets 0x0 to 0x7 all read 0x00 and memEnable is 0.
- R2: A write to offset 0x0 with bit 7 set clears every register at offsets 0x0 to 0x7 to 0x00 at that clock edge, so memEnable is 0 afterwards.
- R3: Offsets 0x0 to 0x7 read back the byte last written to them (0x7 is the general-purpose register), except as stated in R4.
- R4: Bit 0 of offset 0x1 reads 1 and ignores writes while slot16 is 1, keeping its earlier stored value; while slot16 is 0 it is read/write.
- R5: memEnable equals bit 6 of offset 0x0.
- R6: memBase[18:13] equals bits 5:0 of offset 0x0; memBase[23:19] equals bits 4:0 of offset 0x5 when slot16 is 1, and 5'b00001 when slot16 is 0.
- R7: winSizeKb is 8 when slot16 is 0 and 16 when it is 1, multiplied by 4 when bit 3 of offset 0x1 is set.
- R8: irqLevel is picked by the index {offset 0x1 bit 2, offset 0x4 bits 6:5} from the list 9, 3, 5, 7, 10, 11, 15, 4 (index 0 first).
- R9: zeroWait16, lan16En and mem16En equal bits 5, 6 and 7 of offset 0x5 when slot16 is 1, and are 0 when slot16 is 0.
- R10: Offsets 0x8 to 0xD read the station address, most significant byte at 0x8. Offset 0xE reads the card identity byte. Offset 0xF reads a checksum that makes the 8-bit sum of all eight bytes equal 0xFF.
- R11: Writes to offsets 0x8 to 0xF change no register and no derived output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Offset in the I/O window |
| wrEn | input | 1 | Write strobe for the addressed byte |
| wrData | input | 8 | Write data |
| slot16 | input | 1 | Card sits in a 16-bit slot |
| rdData | output | 8 | Read data for the addressed offset |
| memEnable | output | 1 | Shared memory enabled |
| memBase | output | 11 | Shared-memory window base, address bits 23:13 |
| winSizeKb | output | 7 | Shared-memory window size in KiB |
| irqLevel | output | 4 | Interrupt line number |
| zeroWait16 | output | 1 | Zero wait states for 16-bit accesses |
| lan16En | output | 1 | 16-bit network-side transfers enabled |
| mem16En | output | 1 | 16-bit memory accesses enabled |

## Verification
The assertions assume that the slot strap is stable at each rising edge and changes only between edges, as a strap does. They also assume that address and write strobe are settled before the edge, so a read and the write just before it relate through exactly one register stage. The bench drives all inputs on the falling edge and moves the strap only while no write is pending. This keeps the stimulus inside those assumptions while it still crosses both slot widths, the software-clear write and the read-only area.

// File: rtl/busif_pkg.sv
package busif_pkg;

  localparam int REG_COUNT = 8;
  localparam int ROM_COUNT = 8;
  localparam int IDX_W     = $clog2(REG_COUNT);

  localparam logic [IDX_W-1:0] MSR_IDX  = 3'd0;
  localparam logic [IDX_W-1:0] ICR_IDX  = 3'd1;
  localparam logic [IDX_W-1:0] IRR_IDX  = 3'd4;
  localparam logic [IDX_W-1:0] LAAR_IDX = 3'd5;

  typedef struct packed {
    logic [REG_COUNT-1:0] regWr;
    logic                 swClear;
  } busif_strobe_t;

  function automatic logic [3:0] irqMap(input logic [2:0] idx);
    case (idx)
      3'd0: irqMap = 4'd9;
      3'd1: irqMap = 4'd3;
      3'd2: irqMap = 4'd5;
      3'd3: irqMap = 4'd7;
      3'd4: irqMap = 4'd10;
      3'd5: irqMap = 4'd11;
      3'd6: irqMap = 4'd15;
      default: irqMap = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/busif_ctrl.sv
module busif_ctrl
  import busif_pkg::*;
(
  input  logic [3:0]    addr,
  input  logic          wrEn,
  input  logic          clearBit,
  output busif_strobe_t strobe
);

  logic inRegArea;
  assign inRegArea = wrEn && !addr[3];

  genvar g;
  generate
    for (g = 0; g < REG_COUNT; g++) begin : gDec
      assign strobe.regWr[g] = inRegArea && (addr[IDX_W-1:0] == IDX_W'(g));
    end
  endgenerate

  assign strobe.swClear = inRegArea && (addr[IDX_W-1:0] == MSR_IDX) && clearBit;

endmodule

// File: rtl/busif_dp.sv
module busif_dp
  import busif_pkg::*;
#(
  parameter logic [47:0] LAN_ADDR = 48'h0260_8C12_3456,
  parameter logic [7:0]  CARD_ID  = 8'h2A
) (
  input  logic          clk,
  input  logic          rstN,
  input  busif_strobe_t strobe,
  input  logic [7:0]    wrData,
  input  logic [3:0]    addr,
  input  logic          slot16,
  output logic [7:0]    rdData,
  output logic          memEnable,
  output logic [23:13]  memBase,
  output logic [6:0]    winSizeKb,
  output logic [3:0]    irqLevel,
  output logic          zeroWait16,
  output logic          lan16En,
  output logic          mem16En
);

  function automatic logic [7:0] addrByte(input int i);
    addrByte = LAN_ADDR[47 - 8*i -: 8];
  endfunction

  function automatic logic [7:0] romSum();
    logic [7:0] s;
    s = CARD_ID;
    for (int i = 0; i < 6; i++) s = s + addrByte(i);
    romSum = s;
  endfunction

  localparam logic [7:0] CHECK_BYTE = 8'hFF - romSum();

  logic [7:0] regQ [REG_COUNT];
  logic [7:0] icrView;
  logic [7:0] romData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regQ[i] <= '0;
    end else if (strobe.swClear) begin
      for (int i = 0; i < REG_COUNT; i++) regQ[i] <= '0;
    end else begin
      for (int i = 0; i < REG_COUNT; i++) begin
        if (strobe.regWr[i]) begin
          if (IDX_W'(i) == ICR_IDX)
            regQ[i] <= {wrData[7:1], slot16 ? regQ[i][0] : wrData[0]};
          else
            regQ[i] <= wrData;
        end
      end
    end
  end

  assign icrView = {regQ[ICR_IDX][7:1], regQ[ICR_IDX][0] | slot16};

  always_comb begin
    case (addr[2:0])
      3'd6:    romData = CARD_ID;
      3'd7:    romData = CHECK_BYTE;
      default: romData = LAN_ADDR[47 - 8*addr[2:0] -: 8];
    endcase
  end

  always_comb begin
    if (addr[3])
      rdData = romData;
    else if (addr[IDX_W-1:0] == ICR_IDX)
      rdData = icrView;
    else
      rdData = regQ[addr[IDX_W-1:0]];
  end

  logic [6:0] baseKb;

  assign memEnable     = regQ[MSR_IDX][6];
  assign memBase[18:13] = regQ[MSR_IDX][5:0];
  assign memBase[23:19] = slot16 ? regQ[LAAR_IDX][4:0] : 5'b00001;
  assign baseKb        = slot16 ? 7'd16 : 7'd8;
  assign winSizeKb     = regQ[ICR_IDX][3] ? (baseKb << 2) : baseKb;
  assign irqLevel      = irqMap({regQ[ICR_IDX][2], regQ[IRR_IDX][6:5]});
  assign zeroWait16    = slot16 & regQ[LAAR_IDX][5];
  assign lan16En       = slot16 & regQ[LAAR_IDX][6];
  assign mem16En       = slot16 & regQ[LAAR_IDX][7];

endmodule

// File: rtl/busIfRegFile.sv
module busIfRegFile
  import busif_pkg::*;
#(
  parameter logic [47:0] LAN_ADDR = 48'h0260_8C12_3456,
  parameter logic [7:0]  CARD_ID  = 8'h2A
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [3:0]   addr,
  input  logic         wrEn,
  input  logic [7:0]   wrData,
  input  logic         slot16,
  output logic [7:0]   rdData,
  output logic         memEnable,
  output logic [23:13] memBase,
  output logic [6:0]   winSizeKb,
  output logic [3:0]   irqLevel,
  output logic         zeroWait16,
  output logic         lan16En,
  output logic         mem16En
);

  busif_strobe_t strobe;

  busif_ctrl i_ctrl (
    .addr     (addr),
    .wrEn     (wrEn),
    .clearBit (wrData[7]),
    .strobe   (strobe)
  );

  busif_dp #(.LAN_ADDR(LAN_ADDR), .CARD_ID(CARD_ID)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .addr       (addr),
    .slot16     (slot16),
    .rdData     (rdData),
    .memEnable  (memEnable),
    .memBase    (memBase),
    .winSizeKb  (winSizeKb),
    .irqLevel   (irqLevel),
    .zeroWait16 (zeroWait16),
    .lan16En    (lan16En),
    .mem16En    (mem16En)
  );

endmodule

// File: rtl/busif_chk.sv
module busif_chk (
  input logic         clk,
  input logic         rstN,
  input logic [3:0]   addr,
  input logic         wrEn,
  input logic [7:0]   wrData,
  input logic         slot16,
  input logic [7:0]   rdData,
  input logic         memEnable,
  input logic [23:13] memBase,
  input logic [6:0]   winSizeKb,
  input logic [3:0]   irqLevel,
  input logic         zeroWait16,
  input logic         lan16En,
  input logic         mem16En
);

  a_r2_clear_drops_enable: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'h0 && wrData[7]) |=> (!memEnable && memBase[18:13] == 6'd0));

  a_r3_gp_readback: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'h7) ##1 (addr == 4'h7) |-> (rdData == $past(wrData)));

  a_r4_width_bit_forced: assert property (@(posedge clk) disable iff (!rstN)
    (slot16 && addr == 4'h1) |-> rdData[0]);

  a_r6_bit19_in_8bit: assert property (@(posedge clk) disable iff (!rstN)
    !slot16 |-> (memBase[23:19] == 5'b00001));

  a_r7_size_legal: assert property (@(posedge clk) disable iff (!rstN)
    ($onehot(winSizeKb) && winSizeKb >= 7'd8));

  a_r9_flags_8bit_off: assert property (@(posedge clk) disable iff (!rstN)
    !slot16 |-> (!zeroWait16 && !lan16En && !mem16En));

  a_r11_rom_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[3] && $stable(slot16)) |=>
      ($stable(memEnable) && $stable(memBase) && $stable(irqLevel) && $stable(winSizeKb)));

endmodule

bind busIfRegFile busif_chk i_chk (.*);

// File: tb/test_busIfRegFile.sv
module test_busIfRegFile;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   addr = '0;
  logic         wrEn = 1'b0;
  logic [7:0]   wrData = '0;
  logic         slot16 = 1'b0;
  logic [7:0]   rdData;
  logic         memEnable;
  logic [23:13] memBase;
  logic [6:0]   winSizeKb;
  logic [3:0]   irqLevel;
  logic         zeroWait16, lan16En, mem16En;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [47:0] STN = 48'h0260_8C12_3456;
  localparam logic [7:0]  CID = 8'h2A;

  always #10 clk = ~clk;

  busIfRegFile i_busIfRegFile (.*);

  // {addr, write data, expected read} with slot16 = 0
  localparam int NVEC = 9;
  localparam logic [19:0] VEC [NVEC] = '{
    {4'h7, 8'hAA, 8'hAA}, {4'h7, 8'h55, 8'h55}, {4'h1, 8'h0D, 8'h0D},
    {4'h4, 8'h60, 8'h60}, {4'h5, 8'hE3, 8'hE3}, {4'h2, 8'h5A, 8'h5A},
    {4'h3, 8'hC3, 8'hC3}, {4'h6, 8'h81, 8'h81}, {4'h0, 8'h45, 8'h45}
  };

  function automatic logic [3:0] expIrq(input int i);
    case (i)
      0: return 4'd9;  1: return 4'd3;  2: return 4'd5;  3: return 4'd7;
      4: return 4'd10; 5: return 4'd11; 6: return 4'd15; default: return 4'd4;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] sum;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), v);
      check("R1 reset read", v, 8'h00);
    end
    check("R1 memEnable", memEnable, 0);

    // R3 vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd(VEC[i][19:16], v);
      check("R3 readback", v, VEC[i][7:0]);
    end

    // R5, R6, R7 with msr=0x45, icr=0x0D, slot16=0
    check("R5 memEnable set", memEnable, 1);
    check("R6 base 8-bit", memBase, {5'b00001, 6'd5});
    check("R7 size 8-bit x4", winSizeKb, 32);
    wr(4'h1, 8'h00);
    check("R7 size 8-bit", winSizeKb, 8);
    wr(4'h0, 8'h05);
    check("R5 memEnable clear", memEnable, 0);
    check("R9 flags 8-bit", {zeroWait16, lan16En, mem16En}, 3'b000);

    // R8 interrupt map
    for (int i = 0; i < 8; i++) begin
      wr(4'h1, (i >= 4) ? 8'h04 : 8'h00);
      wr(4'h4, 8'((i % 4) << 5) | 8'h01);
      check("R8 irq", irqLevel, expIrq(i));
    end

    // R4 width bit in 8-bit slot: read/write
    wr(4'h1, 8'h01); rd(4'h1, v); check("R4 rw set", v, 8'h01);
    wr(4'h1, 8'h00); rd(4'h1, v); check("R4 rw clr", v, 8'h00);

    // R4, R6, R7, R9 in 16-bit slot
    @(negedge clk); slot16 = 1'b1;
    rd(4'h1, v); check("R4 forced one", v, 8'h01);
    wr(4'h1, 8'h08); rd(4'h1, v); check("R4 write ignored", v, 8'h09);
    check("R7 size 16-bit x4", winSizeKb, 64);
    wr(4'h1, 8'h01);
    check("R7 size 16-bit", winSizeKb, 16);
    wr(4'h5, 8'hB6);
    wr(4'h0, 8'h4A);
    check("R6 base 16-bit", memBase, {5'h16, 6'h0A});
    check("R9 flags 16-bit", {zeroWait16, lan16En, mem16En}, 3'b101);
    wr(4'h5, 8'h40);
    check("R9 lan only", {zeroWait16, lan16En, mem16En}, 3'b010);
    @(negedge clk); slot16 = 1'b0;
    rd(4'h1, v); check("R4 stored bit kept", v, 8'h00);
    check("R9 flags gated", {zeroWait16, lan16En, mem16En}, 3'b000);

    // R10 ROM contents and checksum
    sum = 8'h00;
    for (int i = 0; i < 8; i++) begin
      rd(4'(8 + i), v);
      sum = sum + v;
      if (i < 6) check("R10 station byte", v, STN[47 - 8*i -: 8]);
      if (i == 6) check("R10 card id", v, CID);
    end
    check("R10 checksum", sum, 8'hFF);

    // R11 writes to read-only area
    wr(4'h8, 8'h00); rd(4'h8, v); check("R11 rom unchanged", v, 8'h02);
    wr(4'hF, 8'h00);
    check("R11 base unchanged", memBase, {5'b00001, 6'h0A});
    check("R11 enable unchanged", memEnable, 1);
    rd(4'h0, v); check("R11 msr unchanged", v, 8'h4A);

    // R2 software clear
    wr(4'h7, 8'h3C);
    wr(4'h0, 8'h80);
    check("R2 memEnable", memEnable, 0);
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), v);
      check("R2 cleared", v, 8'h00);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule